// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block is the device-side command decoder for a parallel NOR-style flash array. It watches host write cycles and recognises the two-write unlock prefix. It then accepts either a chip-wide erase or a sector erase. A sector erase leaves a selection window open. More sectors can be added to the same erase while the window is open, and each addition restarts the window. When the window runs out with no new selection, a simple erase engine starts. The engine only counts cycles.

While a window or an erase is active, host reads return a status byte instead of array contents. The status byte shows a busy polarity bit, a bit that flips on every read, and a bit that separates the selection window from the erase itself.

No real array is modelled. A bitmap records which sectors have completed an erase. Array reads return all-ones for those sectors and all-zeros for the others. The window length and the erase duration are both parameters, counted in clock cycles.

Top module: `nor_erase_sequencer`

## Requirements
- R1: After reset, `busy` is 0, `erased_map` is all zeros, `rd_data` is 00h, and the decoder is in read mode.
- R2: Six writes start a sector erase. The command address is `addr[10:0]` and the data is `wr_data`. In order, the writes are AAh at 555h, 55h at 2AAh, 80h at 555h, AAh at 555h, 55h at 2AAh, and finally 30h at any address. The final write selects the sector given by the top SECT_W bits of `addr`, and `busy` is 1 from the cycle after it.
- R3: After the same five-write prefix, a sixth write of 10h at 555h starts a chip erase at once, with no selection window. When it completes, every bit of `erased_map` is 1.
- R4: A write during the first five steps that does not match the expected address and data returns the decoder to its idle state. Writes that would have completed the old sequence then start no erase, and `busy` stays 0.
- R5: After a sector selection, another 30h write within WIN_CYC cycles adds its sector and restarts the window. A write on exactly the WIN_CYC-th cycle still counts. The erase begins WIN_CYC cycles after the last selection if no write intervenes.
- R6: During the selection window, any write whose data is neither 30h nor B0h aborts the erase. `busy` drops on the next cycle and no sector is marked erased.
- R7: During the selection window, a write of B0h neither aborts the sequence nor restarts the window.
- R8: Status bit 3 of a read during the selection window is 0. During the erase it is 1.
- R9: Every status read returns bit 7 = 0. It returns bit 6 equal to a flag that starts at 0 after reset and inverts after each status read. Bits 5, 4, 2, 1 and 0 are 0.
- R10: An erase stays busy for exactly ERASE_CYC cycles. It then returns to read mode, ORs the selected sectors into `erased_map`, and clears the selection so that a later erase marks only its own sectors.
- R11: An array read (`rd_en` while not busy) presents, one cycle later, FFh if the addressed sector is marked erased and 00h otherwise. `rd_data` holds between reads, and no bit of `erased_map` ever clears.
- R12: Writes during an erase are ignored. They neither extend the erase nor start a new sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Host address for reads and writes; top SECT_W bits pick the sector |
| wr_en | input | 1 | Write strobe, one cycle per host write |
| wr_data | input | 8 | Host write data (command byte) |
| rd_en | input | 1 | Read strobe, one cycle per host read |
| rd_data | output | 8 | Registered read result: status byte when busy, array value otherwise |
| busy | output | 1 | High during the selection window and the erase |
| erased_map | output | 2**SECT_W | One bit per sector, set once that sector has been erased |

## Verification
The assertions check cycle-level facts on every clock:
- an erase cannot end before its timer reaches zero;
- an illegal write in the window always returns the decoder to idle;
- a timer reload always lands on its full count;
- the selection clears on commit;
- the erased bitmap never loses a bit;
- status reads keep their fixed-zero bits.

The longer-range behaviour can only be shown by the bench scenarios. That covers exact window and erase lengths, a selection landing on the last window cycle, B0h tolerance, abandoned prefixes, writes during an erase, the toggle sequence across reads, and which sectors end up erased. The bench checks these against a behavioural reference model on every cycle.

// File: rtl/nes_pkg.sv
package nes_pkg;
  localparam int DW     = 8;
  localparam int CMD_AW = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_ARM,
    ST_UNL4,
    ST_UNL5,
    ST_WINDOW,
    ST_ERASE
  } nes_state_e;

  localparam logic [DW-1:0] CODE_KEY_A   = 8'hAA;
  localparam logic [DW-1:0] CODE_KEY_B   = 8'h55;
  localparam logic [DW-1:0] CODE_SETUP   = 8'h80;
  localparam logic [DW-1:0] CODE_SECTOR  = 8'h30;
  localparam logic [DW-1:0] CODE_CHIP    = 8'h10;
  localparam logic [DW-1:0] CODE_SUSPEND = 8'hB0;

  localparam logic [CMD_AW-1:0] ADR_KEY_A = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_KEY_B = 11'h2AA;
endpackage

// File: rtl/nes_down_timer.sv
module nes_down_timer #(
  parameter int MAXV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic en,
  output logic zero
);
  localparam int CW = $clog2(MAXV + 1);
  localparam logic [CW-1:0] TOP = CW'(MAXV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= TOP;
    end else if (en && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

  // R5
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == TOP);

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);
endmodule

// File: rtl/nes_cmd_fsm.sv
module nes_cmd_fsm
  import nes_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              win_zero,
  input  logic              ers_zero,
  output nes_state_e        state,
  output logic              win_load,
  output logic              ers_load,
  output logic              sel_add,
  output logic              sel_all,
  output logic              sel_clr,
  output logic              commit
);
  nes_state_e nxt;

  function automatic logic hit(input logic [CMD_AW-1:0] a, input logic [DW-1:0] d,
                               input logic [CMD_AW-1:0] ea, input logic [DW-1:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  always_comb begin
    nxt      = state;
    win_load = 1'b0;
    ers_load = 1'b0;
    sel_add  = 1'b0;
    sel_all  = 1'b0;
    sel_clr  = 1'b0;
    commit   = 1'b0;
    unique case (state)
      ST_IDLE:
        if (wr_en) nxt = hit(cmd_addr, wr_data, ADR_KEY_A, CODE_KEY_A) ? ST_UNL1 : ST_IDLE;
      ST_UNL1:
        if (wr_en) nxt = hit(cmd_addr, wr_data, ADR_KEY_B, CODE_KEY_B) ? ST_UNL2 : ST_IDLE;
      ST_UNL2:
        if (wr_en) nxt = hit(cmd_addr, wr_data, ADR_KEY_A, CODE_SETUP) ? ST_ARM : ST_IDLE;
      ST_ARM:
        if (wr_en) nxt = hit(cmd_addr, wr_data, ADR_KEY_A, CODE_KEY_A) ? ST_UNL4 : ST_IDLE;
      ST_UNL4:
        if (wr_en) nxt = hit(cmd_addr, wr_data, ADR_KEY_B, CODE_KEY_B) ? ST_UNL5 : ST_IDLE;
      ST_UNL5:
        if (wr_en) begin
          if (wr_data == CODE_SECTOR) begin
            nxt      = ST_WINDOW;
            win_load = 1'b1;
            sel_add  = 1'b1;
          end else if (hit(cmd_addr, wr_data, ADR_KEY_A, CODE_CHIP)) begin
            nxt      = ST_ERASE;
            ers_load = 1'b1;
            sel_all  = 1'b1;
          end else begin
            nxt = ST_IDLE;
          end
        end
      ST_WINDOW:
        if (wr_en && wr_data == CODE_SECTOR) begin
          win_load = 1'b1;
          sel_add  = 1'b1;
        end else if (wr_en && wr_data != CODE_SUSPEND) begin
          nxt     = ST_IDLE;
          sel_clr = 1'b1;
        end else if (win_zero) begin
          nxt      = ST_ERASE;
          ers_load = 1'b1;
        end
      ST_ERASE:
        if (ers_zero) begin
          nxt    = ST_IDLE;
          commit = 1'b1;
        end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  // R10
  erase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERASE && !ers_zero) |=> state == ST_ERASE);

  // R6
  window_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WINDOW && wr_en && wr_data != CODE_SECTOR && wr_data != CODE_SUSPEND)
      |=> state == ST_IDLE);

  // R3
  chip_start_chk: assert property (@(posedge clk) disable iff (rst)
    sel_all |=> state == ST_ERASE);
endmodule

// File: rtl/nes_sector_map.sv
module nes_sector_map #(
  parameter int SECT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sel_add,
  input  logic                   sel_all,
  input  logic                   sel_clr,
  input  logic                   commit,
  input  logic [SECT_W-1:0]      sect_idx,
  output logic [(1<<SECT_W)-1:0] sel_map,
  output logic [(1<<SECT_W)-1:0] erased_map
);
  localparam int SECT_N = 1 << SECT_W;

  for (genvar g = 0; g < SECT_N; g++) begin : g_sect
    logic sel_q;
    logic ers_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q <= 1'b0;
        ers_q <= 1'b0;
      end else if (commit) begin
        ers_q <= ers_q | sel_q;
        sel_q <= 1'b0;
      end else if (sel_clr) begin
        sel_q <= 1'b0;
      end else if (sel_all || (sel_add && sect_idx == SECT_W'(g))) begin
        sel_q <= 1'b1;
      end
    end
    assign sel_map[g]    = sel_q;
    assign erased_map[g] = ers_q;
  end

  // R10
  commit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> sel_map == '0);

  // R11
  erased_keep_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (erased_map & $past(erased_map)) == $past(erased_map));
endmodule

// File: rtl/nes_read_port.sv
module nes_read_port
  import nes_pkg::*;
#(
  parameter int SECT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic                   busy,
  input  logic                   erasing,
  input  logic [SECT_W-1:0]      sect_idx,
  input  logic [(1<<SECT_W)-1:0] erased_map,
  output logic [DW-1:0]          rd_data
);
  logic tog;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      tog     <= 1'b0;
    end else if (rd_en) begin
      if (busy) begin
        rd_data <= {1'b0, tog, 2'b00, erasing, 3'b000};
        tog     <= ~tog;
      end else begin
        rd_data <= {DW{erased_map[sect_idx]}};
      end
    end
  end

  // R9
  status_zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy) |=> (rd_data & 8'b1011_0111) == 8'h00);

  // R11
  array_value_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !busy) |=> (rd_data == 8'h00 || rd_data == 8'hFF));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/nor_erase_sequencer.sv
module nor_erase_sequencer
  import nes_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int SECT_W    = 3,
  parameter int WIN_CYC   = 64,
  parameter int ERASE_CYC = 500
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr_en,
  input  logic [7:0]             wr_data,
  input  logic                   rd_en,
  output logic [7:0]             rd_data,
  output logic                   busy,
  output logic [(1<<SECT_W)-1:0] erased_map
);
  localparam int SECT_N = 1 << SECT_W;

  nes_state_e          state;
  logic                win_load, ers_load, win_zero, ers_zero;
  logic                sel_add, sel_all, sel_clr, commit;
  logic [SECT_N-1:0]   sel_map;
  logic [SECT_W-1:0]   sect_idx;
  logic [CMD_AW-1:0]   cmd_addr;
  logic                erasing;

  assign sect_idx = addr[ADDR_W-1 -: SECT_W];
  assign cmd_addr = addr[CMD_AW-1:0];
  assign erasing  = (state == ST_ERASE);
  assign busy     = (state == ST_WINDOW) || erasing;

  nes_cmd_fsm u_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cmd_addr(cmd_addr), .wr_data(wr_data),
    .win_zero(win_zero), .ers_zero(ers_zero), .state(state),
    .win_load(win_load), .ers_load(ers_load), .sel_add(sel_add),
    .sel_all(sel_all), .sel_clr(sel_clr), .commit(commit)
  );

  nes_down_timer #(.MAXV(WIN_CYC)) u_win_tmr (
    .clk(clk), .rst(rst), .load(win_load), .en(state == ST_WINDOW), .zero(win_zero)
  );

  nes_down_timer #(.MAXV(ERASE_CYC)) u_ers_tmr (
    .clk(clk), .rst(rst), .load(ers_load), .en(erasing), .zero(ers_zero)
  );

  nes_sector_map #(.SECT_W(SECT_W)) u_map (
    .clk(clk), .rst(rst), .sel_add(sel_add), .sel_all(sel_all), .sel_clr(sel_clr),
    .commit(commit), .sect_idx(sect_idx), .sel_map(sel_map), .erased_map(erased_map)
  );

  nes_read_port #(.SECT_W(SECT_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .busy(busy), .erasing(erasing),
    .sect_idx(sect_idx), .erased_map(erased_map), .rd_data(rd_data)
  );

  // R12
  erase_ignores_write_chk: assert property (@(posedge clk) disable iff (rst)
    (erasing && !ers_zero && wr_en) |=> erasing);
endmodule

// File: tb/nor_erase_sequencer_bench.sv
module nor_erase_sequencer_bench;
  localparam int AW  = 14;
  localparam int SW  = 3;
  localparam int NS  = 1 << SW;
  localparam int WIN = 20;
  localparam int ERS = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    rd_data;
  logic          busy;
  logic [NS-1:0] erased_map;

  always #4 clk = ~clk;

  nor_erase_sequencer #(.ADDR_W(AW), .SECT_W(SW), .WIN_CYC(WIN), .ERASE_CYC(ERS)) u_nor_erase_sequencer (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .busy(busy), .erased_map(erased_map)
  );

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  // behavioural reference: phase 0..5 = prefix progress, 6 = window, 7 = erase
  int            m_phase, m_win, m_ers;
  bit            m_tog;
  bit [NS-1:0]   m_sel, m_erased;
  logic [7:0]    m_rd;
  bit            m_busy;
  int            seq_adr [5] = '{'h555, 'h2AA, 'h555, 'h555, 'h2AA};
  int            seq_dat [5] = '{'hAA, 'h55, 'h80, 'hAA, 'h55};

  always @(posedge clk) begin
    int sidx;
    int low;
    sidx = int'(addr) >> (AW - SW);
    low  = int'(addr) % 2048;
    if (rst) begin
      m_phase = 0; m_win = 0; m_ers = 0; m_tog = 0;
      m_sel = '0; m_erased = '0; m_rd = 8'h00;
    end else begin
      if (rd_en) begin
        if (m_phase >= 6) begin
          m_rd  = {1'b0, m_tog, 2'b00, (m_phase == 7), 3'b000};
          m_tog = !m_tog;
        end else begin
          m_rd = m_erased[sidx] ? 8'hFF : 8'h00;
        end
      end
      if (m_phase == 7) begin
        m_ers--;
        if (m_ers == 0) begin
          m_erased |= m_sel;
          m_sel = '0;
          m_phase = 0;
        end
      end else if (m_phase == 6) begin
        if (wr_en && wr_data == 8'h30) begin
          m_sel[sidx] = 1'b1;
          m_win = WIN;
        end else if (wr_en && wr_data != 8'hB0) begin
          m_phase = 0;
          m_sel = '0;
        end else begin
          m_win--;
          if (m_win == 0) begin
            m_phase = 7;
            m_ers = ERS;
          end
        end
      end else if (wr_en) begin
        if (m_phase < 5) begin
          if (low == seq_adr[m_phase] && int'(wr_data) == seq_dat[m_phase]) m_phase++;
          else m_phase = 0;
        end else if (wr_data == 8'h30) begin
          m_phase = 6; m_sel[sidx] = 1'b1; m_win = WIN;
        end else if (wr_data == 8'h10 && low == 'h555) begin
          m_phase = 7; m_sel = '1; m_ers = ERS;
        end else begin
          m_phase = 0;
        end
      end
    end
    m_busy = (m_phase >= 6);
  end

  task automatic compare();
    vectors++;
    if (busy !== m_busy || erased_map !== m_erased || rd_data !== m_rd) begin
      miscompares++;
      $display("FAIL %s: actual busy=%0b map=%b rd=%h expected busy=%0b map=%b rd=%h",
               cur_req, busy, erased_map, rd_data, m_busy, m_erased, m_rd);
    end
  endtask

  task automatic tick(input bit w, input int a, input int d, input bit r);
    wr_en = w; addr = a[AW-1:0]; wr_data = d[7:0]; rd_en = r;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    compare();
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0);
  endtask

  function automatic int sa(input int s, input int low);
    return (s << (AW - SW)) | low;
  endfunction

  task automatic prefix();
    for (int i = 0; i < 5; i++) tick(1, seq_adr[i], seq_dat[i], 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL %s: actual watchdog expired expected run complete", cur_req);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    cur_req = "R1";
    wait_cyc(3);
    // R11 array read of an unerased sector
    cur_req = "R11";
    tick(0, sa(2, 0), 0, 1);
    wait_cyc(1);

    // R2 single sector erase with status reads
    cur_req = "R2";
    prefix();
    tick(1, sa(3, 'h12), 'h30, 0);
    cur_req = "R8";
    tick(0, 0, 0, 1);
    tick(0, 0, 0, 1);
    tick(0, 0, 0, 1);
    cur_req = "R5";
    wait_cyc(WIN);
    cur_req = "R9";
    tick(0, 0, 0, 1);
    tick(0, 0, 0, 1);
    cur_req = "R10";
    wait_cyc(ERS);
    cur_req = "R11";
    tick(0, sa(3, 0), 0, 1);
    tick(0, sa(2, 0), 0, 1);

    // R5 multi-sector, last add on the final window cycle
    cur_req = "R5";
    prefix();
    tick(1, sa(1, 0), 'h30, 0);
    wait_cyc(WIN - 2);
    tick(1, sa(5, 0), 'h30, 0);
    wait_cyc(WIN - 1);
    tick(1, sa(6, 'h7), 'h30, 0);
    cur_req = "R10";
    wait_cyc(WIN + ERS + 2);

    // R6 abort in window
    cur_req = "R6";
    prefix();
    tick(1, sa(0, 0), 'h30, 0);
    wait_cyc(3);
    tick(1, sa(0, 0), 'hF0, 0);
    wait_cyc(WIN + ERS);
    tick(0, sa(0, 0), 0, 1);

    // R7 suspend code tolerated in window
    cur_req = "R7";
    prefix();
    tick(1, sa(4, 0), 'h30, 0);
    wait_cyc(2);
    tick(1, sa(4, 0), 'hB0, 0);
    wait_cyc(WIN + ERS);
    tick(0, sa(4, 0), 0, 1);

    // R4 broken prefixes
    cur_req = "R4";
    tick(1, 'h555, 'hAA, 0);
    tick(1, 'h2AA, 'h55, 0);
    tick(1, 'h555, 'h80, 0);
    tick(1, 'h555, 'hAA, 0);
    tick(1, 'h2AA, 'h22, 0);
    tick(1, sa(7, 0), 'h30, 0);
    wait_cyc(WIN + 2);
    tick(1, 'h555, 'hAA, 0);
    tick(1, 'h2AB, 'h55, 0);
    tick(1, 'h555, 'h80, 0);
    tick(1, 'h555, 'hAA, 0);
    tick(1, 'h2AA, 'h55, 0);
    tick(1, 'h555, 'h10, 0);
    wait_cyc(ERS + 2);
    tick(0, sa(7, 0), 0, 1);

    // R3 chip erase, with R12 writes during it
    cur_req = "R3";
    prefix();
    tick(1, 'h555, 'h10, 0);
    tick(0, 0, 0, 1);
    cur_req = "R12";
    prefix();
    tick(1, sa(7, 0), 'h30, 0);
    tick(1, 'h555, 'hF0, 0);
    wait_cyc(ERS);
    cur_req = "R3";
    tick(0, sa(7, 0), 0, 1);
    tick(0, sa(0, 0), 0, 1);
    wait_cyc(3);
    finish_run();
  end
endmodule